// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-visible register file of a multi-channel DMA controller. A CPU reaches it through a simple word-wide write and read port. Through that port it sets each channel's transfer mode and direction, enables each channel's interrupt and kicks channels off. It also loads the four working descriptor words (device address, memory address, size, next link) that each channel engine consumes. The channel engines are not part of this block.

The engines report back through three kinds of inputs. One is a done pulse per channel. Another is an error pulse per channel. The third is a live 2-bit activity state per channel. Done and error pulses latch sticky flags, and software clears those flags by writing ones to the status word. A single interrupt line is raised whenever any flagged channel has its interrupt enabled. Start requests are turned into one-cycle pulses towards the engines, and a channel only receives one while it reports idle.

Top module: `dmac_regbank`

## Requirements
- R1: Control word at 0x00 holds a 4-bit slice per channel at bit 4*ch. Bits [1:0] of the slice are the mode (0 off, 1 chained descriptors, 2 single descriptor, 3 stored as written). Bit 2 is the direction (1 memory to device, 0 device to memory). Bit 3 and the slices of absent channels read 0. `ch_mode[2*ch+:2]` and `ch_dir[ch]` show the stored fields from the clock edge of the write.
- R2: Control word at 0x08 keeps interrupt enables in bits [NCH-1:0]. Its start bits (8+ch) always read back as 0.
- R3: Writing 1 to bit 8+ch of 0x08 raises `ch_start[ch]` for exactly the one cycle after the write. This happens only if `eng_state[2*ch+:2]` is 0 (idle) in the write cycle; otherwise the request is dropped.
- R4: A pulse on `eng_done[ch]` sets the interrupt flag (status bit ch at 0x10). A pulse on `eng_err[ch]` sets both that flag and the error flag (status bit 8+ch). Both flags hold until cleared.
- R5: Writing 0x10 clears each interrupt and error flag whose bit is 1 in the written data and leaves the others. A done or error pulse in the same cycle wins over the clear.
- R6: Bits [17+2*ch:16+2*ch] of 0x10 read the live `eng_state` field of channel ch (0 idle, 1 fetching descriptor, 2 waiting, 3 moving data). Writes have no effect on them.
- R7: `irq` is 1 exactly when some channel has both its interrupt flag and its enable set. It changes on the same clock edge as the flag or enable that causes the change.
- R8: Channel ch owns four read/write words at 0x20+16*ch: device address (+0), memory address (+4), size (+8) and next (+12). Word k of channel ch drives `ch_desc[128*ch+32*k+:32]`.
- R9: Offset 0x04 is a plain 32-bit read/write word. Offset 0x14, the reserved offsets 0x0C, 0x18 and 0x1C, every offset past the last channel's descriptors and any address with nonzero bits [1:0] read 0. Writes to any of these change nothing.
- R10: While `rst` is high at a clock edge, every register clears: all controls, flags, descriptors, `ch_start`, `irq` and `bus_rdata` are 0.
- R11: `bus_rdata` loads the addressed word on the edge where `bus_re` is 1, using the register values from before any write in the same cycle. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_state | input | 2*NCH | Live activity state per channel |
| eng_done | input | NCH | Completion pulse per channel |
| eng_err | input | NCH | Error pulse per channel |
| ch_mode | output | 2*NCH | Mode field per channel |
| ch_dir | output | NCH | Direction bit per channel |
| ch_start | output | NCH | One-cycle start pulse per channel |
| ch_desc | output | 128*NCH | Working descriptor words, four per channel |
| irq | output | 1 | Shared interrupt line |

## Verification
Two functions can fall in the same cycle: an engine's done or error pulse, and a software write-one-to-clear of that same channel's flag. The bench drives both in one cycle for a channel whose flag is already set. It then expects the flag to stay set and `irq` to stay high, while flags of other channels named in the write do clear. A second collision places an enable write to 0x08 and an engine event in one cycle, and `irq` is judged on that same edge. The random phase mixes engine events into status writes throughout, and a bench model that applies the clear before the set judges every cycle.

// File: rtl/dmac_regbank_pkg.sv
package dmac_regbank_pkg;
  // Word index (byte offset / 4) of each register
  localparam int W_CTL0  = 0;
  localparam int W_CTL1  = 1;
  localparam int W_CTL2  = 2;
  localparam int W_STS0  = 4;
  localparam int W_DESC0 = 8;
  localparam int DESC_WORDS = 4;   // descriptor words per channel
  localparam int ERR_LSB    = 8;   // error flags / start bits base
  localparam int STATE_LSB  = 16;  // activity fields base

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_MOVE  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs #(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl0,
  input  logic              wr_ctl1,
  input  logic              wr_ctl2,
  input  logic [DW-1:0]     wdata,
  input  logic [NCH-1:0]    eng_idle,
  output logic [DW-1:0]     ctl0_rd,
  output logic [DW-1:0]     ctl1_q,
  output logic [NCH-1:0]    ien_q,
  output logic [NCH-1:0]    ien_nx,
  output logic [NCH-1:0]    start_q,
  output logic [2*NCH-1:0]  mode_flat,
  output logic [NCH-1:0]    dir_q
);
  import dmac_regbank_pkg::*;
  localparam int SLICE   = 4;
  localparam int DIR_BIT = 2;

  logic [NCH-1:0][1:0] mode_q;

  assign ien_nx = wr_ctl2 ? wdata[NCH-1:0] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      dir_q   <= '0;
      ctl1_q  <= '0;
      ien_q   <= '0;
      start_q <= '0;
    end else begin
      if (wr_ctl0) begin
        for (int c = 0; c < NCH; c++) begin
          mode_q[c] <= wdata[SLICE*c +: 2];
          dir_q[c]  <= wdata[SLICE*c + DIR_BIT];
        end
      end
      if (wr_ctl1) ctl1_q <= wdata;
      ien_q   <= ien_nx;
      start_q <= wr_ctl2 ? (wdata[ERR_LSB +: NCH] & eng_idle) : '0;
    end
  end

  always_comb begin
    ctl0_rd = '0;
    for (int c = 0; c < NCH; c++) begin
      ctl0_rd[SLICE*c +: 2]         = mode_q[c];
      ctl0_rd[SLICE*c + DIR_BIT]    = dir_q[c];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    assign mode_flat[2*c +: 2] = mode_q[c];
  end
endmodule

// File: rtl/dmac_status_regs.sv
module dmac_status_regs #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] clr_irq,
  input  logic [NCH-1:0] clr_err,
  input  logic [NCH-1:0] eng_done,
  input  logic [NCH-1:0] eng_err,
  input  logic [NCH-1:0] ien_nx,
  output logic [NCH-1:0] flag_irq,
  output logic [NCH-1:0] flag_err,
  output logic           irq
);
  logic [NCH-1:0] irq_nx, err_nx;

  // clear first, then set: an engine event in the clearing cycle survives
  always_comb begin
    irq_nx = (flag_irq & ~clr_irq) | eng_done | eng_err;
    err_nx = (flag_err & ~clr_err) | eng_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_irq <= '0;
      flag_err <= '0;
      irq      <= 1'b0;
    end else begin
      flag_irq <= irq_nx;
      flag_err <= err_nx;
      irq      <= |(irq_nx & ien_nx);
    end
  end
endmodule

// File: rtl/dmac_desc_regs.sv
module dmac_desc_regs #(
  parameter int NCH   = 8,
  parameter int DW    = 32,
  parameter int SEL_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    sel,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic [NCH*4*DW-1:0] desc_flat
);
  localparam int NW = 4 * NCH;

  logic [DW-1:0] mem [NW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[sel] <= wdata;
    end
  end

  assign rdata = mem[sel];

  for (genvar i = 0; i < NW; i++) begin : g_flat
    assign desc_flat[DW*i +: DW] = mem[i];
  end
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [2*NCH-1:0]     eng_state,
  input  logic [NCH-1:0]       eng_done,
  input  logic [NCH-1:0]       eng_err,
  output logic [2*NCH-1:0]     ch_mode,
  output logic [NCH-1:0]       ch_dir,
  output logic [NCH-1:0]       ch_start,
  output logic [NCH*128-1:0]   ch_desc,
  output logic                 irq
);
  import dmac_regbank_pkg::*;
  localparam int DW     = 32;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int DSEL_W = $clog2(DESC_WORDS * NCH);
  localparam logic [IDX_W-1:0] DESC_FIRST = IDX_W'(W_DESC0);
  localparam logic [IDX_W-1:0] DESC_LAST  = IDX_W'(W_DESC0 + DESC_WORDS*NCH - 1);

  logic [IDX_W-1:0]  widx;
  logic              aligned, in_desc;
  logic              hit_ctl0, hit_ctl1, hit_ctl2, hit_sts0;
  logic [DSEL_W-1:0] dsel;
  logic [NCH-1:0]    eng_idle, ien_q, ien_nx, flag_irq, flag_err, clr_irq, clr_err;
  logic [DW-1:0]     ctl0_rd, ctl1_q, desc_rd, sts_rd, rd_nx;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_desc  = aligned && (widx >= DESC_FIRST) && (widx <= DESC_LAST);
  assign hit_ctl0 = aligned && (widx == IDX_W'(W_CTL0));
  assign hit_ctl1 = aligned && (widx == IDX_W'(W_CTL1));
  assign hit_ctl2 = aligned && (widx == IDX_W'(W_CTL2));
  assign hit_sts0 = aligned && (widx == IDX_W'(W_STS0));
  assign dsel     = DSEL_W'(widx - DESC_FIRST);

  for (genvar c = 0; c < NCH; c++) begin : g_idle
    assign eng_idle[c] = (eng_state[2*c +: 2] == ST_IDLE);
  end

  assign clr_irq = (bus_we && hit_sts0) ? bus_wdata[NCH-1:0] : '0;
  assign clr_err = (bus_we && hit_sts0) ? bus_wdata[ERR_LSB +: NCH] : '0;

  dmac_ctrl_regs #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst),
    .wr_ctl0(bus_we && hit_ctl0), .wr_ctl1(bus_we && hit_ctl1),
    .wr_ctl2(bus_we && hit_ctl2), .wdata(bus_wdata), .eng_idle(eng_idle),
    .ctl0_rd(ctl0_rd), .ctl1_q(ctl1_q), .ien_q(ien_q), .ien_nx(ien_nx),
    .start_q(ch_start), .mode_flat(ch_mode), .dir_q(ch_dir)
  );

  dmac_status_regs #(.NCH(NCH)) u_sts (
    .clk(clk), .rst(rst), .clr_irq(clr_irq), .clr_err(clr_err),
    .eng_done(eng_done), .eng_err(eng_err), .ien_nx(ien_nx),
    .flag_irq(flag_irq), .flag_err(flag_err), .irq(irq)
  );

  dmac_desc_regs #(.NCH(NCH), .DW(DW), .SEL_W(DSEL_W)) u_desc (
    .clk(clk), .rst(rst), .wr_en(bus_we && in_desc), .sel(dsel),
    .wdata(bus_wdata), .rdata(desc_rd), .desc_flat(ch_desc)
  );

  always_comb begin
    sts_rd = '0;
    for (int c = 0; c < NCH; c++) begin
      sts_rd[c]                   = flag_irq[c];
      sts_rd[ERR_LSB + c]         = flag_err[c];
      sts_rd[STATE_LSB + 2*c +: 2] = eng_state[2*c +: 2];
    end
  end

  always_comb begin
    rd_nx = '0;
    if (in_desc)       rd_nx = desc_rd;
    else if (hit_ctl0) rd_nx = ctl0_rd;
    else if (hit_ctl1) rd_nx = ctl1_q;
    else if (hit_ctl2) rd_nx = DW'(ien_q);
    else if (hit_sts0) rd_nx = sts_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_nx;
  end
endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [2*NCH-1:0]  eng_state,
  input logic [NCH-1:0]    eng_done,
  input logic [NCH-1:0]    eng_err,
  input logic [NCH-1:0]    ch_start,
  input logic              irq,
  input logic [NCH-1:0]    flag_irq,
  input logic [NCH-1:0]    flag_err,
  input logic [NCH-1:0]    ien_q
);
  logic wr_ctl2, wr_sts0;
  assign wr_ctl2 = bus_we && (bus_addr == ADDR_W'(8));
  assign wr_sts0 = bus_we && (bus_addr == ADDR_W'(16));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R3: a start pulse traces back to a start write while the channel was idle
    a_r3_start_from_idle_write: assert property (@(posedge clk) disable iff (rst)
      ch_start[c] |-> $past(wr_ctl2 && bus_wdata[8+c] && (eng_state[2*c +: 2] == 2'd0)));
    // R4: any engine event leaves the interrupt flag set
    a_r4_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
      (eng_done[c] || eng_err[c]) |=> flag_irq[c]);
    // R4: an error event leaves the error flag set
    a_r4_err_sets_err: assert property (@(posedge clk) disable iff (rst)
      eng_err[c] |=> flag_err[c]);
    // R5: a clear without a competing event removes the flag
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
      (wr_sts0 && bus_wdata[c] && !eng_done[c] && !eng_err[c]) |=> !flag_irq[c]);
  end

  // R7: interrupt line agrees with flags and enables
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == |(flag_irq & ien_q));
  // R10: reset leaves outputs quiet
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && (ch_start == '0) && (bus_rdata == '0)));
endmodule

bind dmac_regbank dmac_regbank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_state(eng_state),
  .eng_done(eng_done), .eng_err(eng_err), .ch_start(ch_start), .irq(irq),
  .flag_irq(flag_irq), .flag_err(flag_err), .ien_q(ien_q)
);

// File: tb/dmac_regbank_tb.sv
module dmac_regbank_tb;
  localparam int NCH = 8;
  localparam int AW  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_we = 0, bus_re = 0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [2*NCH-1:0]  st = '0;
  logic [NCH-1:0]    eng_done = '0, eng_err = '0;
  logic [2*NCH-1:0]  ch_mode;
  logic [NCH-1:0]    ch_dir, ch_start;
  logic [NCH*128-1:0] ch_desc;
  logic              irq;

  dmac_regbank #(.NCH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_state(st),
    .eng_done(eng_done), .eng_err(eng_err), .ch_mode(ch_mode), .ch_dir(ch_dir),
    .ch_start(ch_start), .ch_desc(ch_desc), .irq(irq)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic [31:0]    m_ctl0 = '0, m_ctl1 = '0;
  logic [NCH-1:0] m_ien = '0, m_irqf = '0, m_errf = '0;
  logic [31:0]    m_desc [4*NCH];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl0_mask();
    logic [31:0] m = '0;
    for (int c = 0; c < NCH; c++) m |= 32'h7 << (4*c);
    return m;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int idx = int'(a >> 2);
    logic [31:0] s = '0;
    if (a[1:0] != 2'b00) return '0;
    if (idx >= 8 && idx < 8 + 4*NCH) return m_desc[idx-8];
    case (idx)
      0: return m_ctl0;
      1: return m_ctl1;
      2: return 32'(m_ien);
      4: begin
        for (int c = 0; c < NCH; c++) begin
          s[c] = m_irqf[c]; s[8+c] = m_errf[c]; s[16+2*c +: 2] = st[2*c +: 2];
        end
        return s;
      end
      default: return '0;
    endcase
  endfunction

  function automatic logic [NCH-1:0] idle_mask();
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) m[c] = (st[2*c +: 2] == 2'd0);
    return m;
  endfunction

  // One bus/engine cycle, then model update and per-cycle checks.
  task automatic cycle(input bit we, input bit re, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic [NCH-1:0] dn,
                       input logic [NCH-1:0] er);
    logic [31:0] exp_rd;
    logic [NCH-1:0] exp_st;
    logic [NCH-1:0] clr_i, clr_e;
    @(negedge clk);
    check("R3 start pulse lasts one cycle", 64'(ch_start), 64'(0));
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; eng_done = dn; eng_err = er;
    exp_rd = exp_read(a);
    exp_st = (we && a == 8'h08) ? (d[8 +: NCH] & idle_mask()) : '0;
    @(negedge clk);
    bus_we = 0; bus_re = 0; eng_done = '0; eng_err = '0;
    clr_i = '0; clr_e = '0;
    if (we && a[1:0] == 2'b00) begin
      int idx = int'(a >> 2);
      if (idx >= 8 && idx < 8 + 4*NCH) m_desc[idx-8] = d;
      else if (idx == 0) m_ctl0 = d & ctl0_mask();
      else if (idx == 1) m_ctl1 = d;
      else if (idx == 2) m_ien = d[NCH-1:0];
      else if (idx == 4) begin clr_i = d[NCH-1:0]; clr_e = d[8 +: NCH]; end
    end
    m_irqf = (m_irqf & ~clr_i) | dn | er;
    m_errf = (m_errf & ~clr_e) | er;
    check("R3 start pulse gated by idle", 64'(ch_start), 64'(exp_st));
    check("R7 irq", 64'(irq), 64'(|(m_irqf & m_ien)));
    for (int c = 0; c < NCH; c++) begin
      if (ch_mode[2*c +: 2] !== m_ctl0[4*c +: 2] || ch_dir[c] !== m_ctl0[4*c+2])
        check("R1 mode/dir outputs", 64'({ch_mode[2*c +: 2], ch_dir[c]}),
              64'({m_ctl0[4*c +: 2], m_ctl0[4*c+2]}));
    end
    if (re) begin
      int idx = int'(a >> 2);
      check("R11 read data", 64'(bus_rdata), 64'(exp_rd));
      if (a[1:0] == 2'b00 && idx >= 8 && idx < 8 + 4*NCH)
        check("R8 descriptor output", 64'(ch_desc[(idx-8)*32 +: 32]), 64'(m_desc[idx-8]));
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    cycle(1'b1, 1'b0, a, d, '0, '0);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    cycle(1'b0, 1'b1, a, '0, '0, '0);
  endtask
  task automatic ev(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
    cycle(1'b0, 1'b0, '0, '0, dn, er);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] held;
    logic [31:0] sd;
    sd = $urandom(32'd1357);
    for (int i = 0; i < 4*NCH; i++) m_desc[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R10: reset state
    check("R10 irq after reset", 64'(irq), 64'(0));
    check("R10 start after reset", 64'(ch_start), 64'(0));
    check("R10 rdata after reset", 64'(bus_rdata), 64'(0));
    check("R10 desc after reset", 64'(ch_desc[63:0]), 64'(0));
    rd(8'h00); rd(8'h08); rd(8'h10); rd(8'h20);

    // R1: slice packing
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
    check("R1 ctl0 readback", 64'(bus_rdata), 64'h7777_7777);
    wr(8'h00, 32'h1234_5602); rd(8'h00);
    check("R1 ctl0 mixed modes", 64'(bus_rdata), 64'(32'h1234_5602 & ctl0_mask()));

    // R2, R3: enables, start pulses with some channels busy
    st = 16'h0080;  // channel 3 waiting
    wr(8'h08, 32'h0000_FF0F); rd(8'h08);
    check("R2 enables read, start bits 0", 64'(bus_rdata), 64'h0000_000F);
    st = '0;
    wr(8'h08, 32'h0000_0100);
    st = 16'hFFFF;  // all busy
    wr(8'h08, 32'h0000_FF00);
    st = '0;

    // R4, R7: events
    wr(8'h08, 32'h0000_00FF);
    ev(8'h04, 8'h00); rd(8'h10);
    check("R4 done sets only irq flag", 64'(bus_rdata), 64'h0000_0004);
    ev(8'h00, 8'h20); rd(8'h10);
    check("R4 error sets both flags", 64'(bus_rdata), 64'h0000_2024);

    // R5: partial clear, then collision with set
    wr(8'h10, 32'h0000_2000); rd(8'h10);
    check("R5 clear error only", 64'(bus_rdata), 64'h0000_0024);
    cycle(1'b1, 1'b0, 8'h10, 32'h0000_0024, 8'h04, 8'h00); rd(8'h10);
    check("R5 set wins over clear", 64'(bus_rdata), 64'h0000_0004);
    check("R5 irq held by surviving flag", 64'(irq), 64'(1));
    // enable write colliding with an event
    cycle(1'b1, 1'b0, 8'h08, 32'h0000_0000, 8'h00, 8'h00);
    cycle(1'b1, 1'b0, 8'h08, 32'h0000_0080, 8'h80, 8'h00);
    check("R7 irq on enable+event edge", 64'(irq), 64'(1));
    wr(8'h10, 32'h0000_FFFF);
    check("R5 all cleared irq low", 64'(irq), 64'(0));

    // R6: live state, writes ignored
    st = 16'hE4_1B;
    wr(8'h10, 32'hFFFF_0000); rd(8'h10);
    check("R6 state fields live", 64'(bus_rdata), 64'h00E4_1B00 << 8);
    st = '0;

    // R8: descriptors, first and last channel
    wr(8'h20, 32'hDEAD_0001); wr(8'h24, 32'hBEEF_0002);
    wr(8'h28, 32'h0000_33FF); wr(8'h2C, 32'hCAFE_0003);
    wr(8'h9C, 32'h1111_2222);
    rd(8'h20); rd(8'h24); rd(8'h28); rd(8'h2C); rd(8'h9C); rd(8'h90);
    check("R8 ch7 next word", 64'(ch_desc[7*128+96 +: 32]), 64'h1111_2222);

    // R9: ctl1 and ignored offsets
    wr(8'h04, 32'hA5A5_5A5A); rd(8'h04);
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF); wr(8'hA0, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h22, 32'hFFFF_FFFF);
    rd(8'h0C); check("R9 reserved reads 0", 64'(bus_rdata), 64'(0));
    rd(8'h14); rd(8'h18); rd(8'h1C); rd(8'hA0); rd(8'hFC); rd(8'h01);
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h10); rd(8'h20);

    // R11: hold between reads; read sees pre-write value
    rd(8'h04); held = bus_rdata;
    ev('0, '0); check("R11 rdata holds", 64'(bus_rdata), 64'(held));
    cycle(1'b1, 1'b1, 8'h04, 32'h0BAD_F00D, '0, '0);
    check("R11 read before write", 64'(bus_rdata), 64'(held));

    // random phase
    for (int it = 0; it < 3000; it++) begin
      int op = $urandom_range(0, 9);
      logic [AW-1:0] a;
      if ($urandom_range(0, 3) == 0) st = 16'($urandom);
      case (op)
        0: wr(8'h00, $urandom);
        1: wr(8'h04, $urandom);
        2: wr(8'h08, $urandom & 32'h0000_FFFF);
        3: cycle(1'b1, 1'b0, 8'h10, $urandom, NCH'($urandom), NCH'($urandom_range(0,3) == 0 ? $urandom : 0));
        4: ev(NCH'($urandom), NCH'($urandom_range(0,2) == 0 ? $urandom : 0));
        5: wr(AW'(32'h20 + 4*$urandom_range(0, 4*NCH-1)), $urandom);
        6: begin
          a = AW'($urandom);
          cycle(1'b1, 1'b0, a, $urandom, '0, '0);
        end
        default: begin
          a = AW'(4*$urandom_range(0, 8 + 4*NCH + 3));
          if ($urandom_range(0, 15) == 0) a[0] = 1'b1;
          rd(a);
        end
      endcase
    end
    summary();
  end
endmodule